// File: doc/BRIEF.md
# Designated-Pointer Scratchpad Register File

This block holds a bank of sixteen 16-bit scratchpad registers, each reachable as a high byte and a low byte. Two 4-bit designators decide which registers act as the program counter and the data pointer. The counter and the pointer are not dedicated registers. They are whichever bank entries the designators name. When a designator is rewritten, the role moves to another register and the old register keeps its value.

A sequencer presents one opcode byte per cycle with a valid strobe, together with the accumulator value. The block decodes the register-directed opcodes: transfers of a byte between the accumulator and a register half, increment and decrement, loading either designator, and saving both designators into an 8-bit save byte. A separate fetch-advance strobe steps the current program counter. The block continuously presents the counter value, the pointer value and a read-back byte for the accumulator. The arithmetic unit, the memory bus, interrupt entry and branching live outside this block.

Top module: `desig_regfile`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both designators, the save byte and all sixteen registers are zero, so pc_out and dp_out read 0.
- R2: In every cycle, pc_out equals the register named by the P designator and dp_out equals the register named by the X designator.
- R3: Opcode 0x1r increments register r and opcode 0x2r decrements it, both modulo 2^16 (0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF).
- R4: Opcode 0x8r (get-low) and 0x9r (get-high) raise acc_load in the same cycle, and acc_data carries the low or high byte of register r as it stood before any update in that cycle.
- R5: Opcode 0xAr (put-low) writes acc_in into bits 7:0 of register r, and 0xBr (put-high) writes it into bits 15:8. The other byte is kept.
- R6: Opcode 0xDr loads P with r. The new counter register is in effect from the next cycle.
- R7: Opcode 0xEr loads X with r. The new pointer register is in effect from the next cycle.
- R8: Opcode 0x79 loads the save byte with X in bits 7:4 and P in bits 3:0.
- R9: A fetch_adv pulse increments, modulo 2^16, the register named by P as it stands in that cycle. An opcode that changes P in the same cycle does not redirect the advance.
- R10: When increment, decrement, put-low or put-high targets the P register in the same cycle as fetch_adv, that write takes priority and the advance is dropped. An increment therefore adds 1, not 2.
- R11: When op_valid is low, and for every other opcode value (0x00 idle, 0x0r, 0x3x to 0x7x apart from 0x79, 0xCx, 0xFx), no register, designator or save byte changes and acc_load stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Opcode byte is to be executed this cycle |
| op_code | input | 8 | Opcode byte: operation in bits 7:4, register number in bits 3:0 |
| acc_in | input | 8 | Accumulator value for put-low and put-high |
| fetch_adv | input | 1 | Step the current program counter register |
| pc_out | output | 16 | Register named by P |
| dp_out | output | 16 | Register named by X |
| acc_load | output | 1 | acc_data is to be loaded into the accumulator |
| acc_data | output | 8 | Byte read by get-low or get-high |
| t_out | output | 8 | Save byte, X in bits 7:4 and P in bits 3:0 |
| p_out | output | 4 | Current P designator |
| x_out | output | 4 | Current X designator |

## Verification
The bound checker watches the port-level rules on every cycle. It checks that the designator loads and the save-byte capture land one cycle later, that an advance with no opcode steps pc_out by one, and that increment and put-low win over a same-cycle advance on the P register. It also checks that get-low of the P register returns pc_out's low byte, that pc_out and dp_out agree when both designators match, and that a cycle with neither strobe leaves everything still. Only the bench's scenarios can show the wrap-around values, that writes land in registers that are not currently designated, that ignored opcode groups leave all sixteen registers untouched, and that read-back stays correct across a long mixed sequence. The bench does this by comparing a behavioural model on every clock and by reading back every register byte.

// File: rtl/drf_pkg.sv
package drf_pkg;

   localparam int OPC_W = 8;
   localparam int NIB_W = 4;

   localparam logic [NIB_W-1:0] NIB_INC  = 4'h1;
   localparam logic [NIB_W-1:0] NIB_DEC  = 4'h2;
   localparam logic [NIB_W-1:0] NIB_MISC = 4'h7;
   localparam logic [NIB_W-1:0] NIB_GLO  = 4'h8;
   localparam logic [NIB_W-1:0] NIB_GHI  = 4'h9;
   localparam logic [NIB_W-1:0] NIB_PLO  = 4'hA;
   localparam logic [NIB_W-1:0] NIB_PHI  = 4'hB;
   localparam logic [NIB_W-1:0] NIB_SEP  = 4'hD;
   localparam logic [NIB_W-1:0] NIB_SEX  = 4'hE;
   localparam logic [NIB_W-1:0] SUB_MARK = 4'h9;

   typedef enum logic [3:0] {
      K_NONE,
      K_INC,
      K_DEC,
      K_GLO,
      K_GHI,
      K_PLO,
      K_PHI,
      K_SEP,
      K_SEX,
      K_MARK
   } op_kind_e;

   typedef struct packed {
      op_kind_e          kind;
      logic [NIB_W-1:0]  sel;
   } dec_op_t;

endpackage

// File: rtl/drf_decode.sv
module drf_decode
   import drf_pkg::*;
(
   input  logic             op_valid,
   input  logic [OPC_W-1:0] op_code,
   output dec_op_t          dec
);

   logic [NIB_W-1:0] op_hi;
   logic [NIB_W-1:0] op_lo;

   assign op_hi = op_code[OPC_W-1:NIB_W];
   assign op_lo = op_code[NIB_W-1:0];

   always_comb begin
      dec.kind = K_NONE;
      dec.sel  = op_lo;
      if (op_valid) begin
         unique case (op_hi)
            NIB_INC: dec.kind = K_INC;
            NIB_DEC: dec.kind = K_DEC;
            NIB_GLO: dec.kind = K_GLO;
            NIB_GHI: dec.kind = K_GHI;
            NIB_PLO: dec.kind = K_PLO;
            NIB_PHI: dec.kind = K_PHI;
            NIB_SEP: dec.kind = K_SEP;
            NIB_SEX: dec.kind = K_SEX;
            NIB_MISC: begin
               if (op_lo == SUB_MARK) dec.kind = K_MARK;
            end
            default: dec.kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/drf_desig.sv
module drf_desig
   import drf_pkg::*;
#(
   parameter int SEL_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  dec_op_t            dec,
   output logic [SEL_W-1:0]   p_q,
   output logic [SEL_W-1:0]   x_q,
   output logic [2*SEL_W-1:0] t_q
);

   logic [SEL_W-1:0] sel_w;
   assign sel_w = SEL_W'(dec.sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_q <= '0;
         x_q <= '0;
         t_q <= '0;
      end else begin
         case (dec.kind)
            K_SEP:   p_q <= sel_w;
            K_SEX:   x_q <= sel_w;
            K_MARK:  t_q <= {x_q, p_q};
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/drf_cell.sv
module drf_cell #(
   parameter int REG_W        = 16,
   parameter int BYTE_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_inc,
   input  logic              en_dec,
   input  logic              en_lo,
   input  logic              en_hi,
   input  logic              en_adv,
   input  logic [BYTE_W-1:0] acc_in,
   output logic [REG_W-1:0]  q
);

   logic [REG_W-1:0] q_r;
   logic [REG_W-1:0] nxt;
   logic [REG_W-1:0] step_val;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [REG_W-1:0] opnd;
         assign opnd     = en_dec ? {REG_W{1'b1}} : REG_W'(1);
         assign step_val = q_r + opnd;
      end else begin : g_split
         logic [REG_W-1:0] up_v;
         logic [REG_W-1:0] dn_v;
         assign up_v     = q_r + REG_W'(1);
         assign dn_v     = q_r - REG_W'(1);
         assign step_val = en_dec ? dn_v : up_v;
      end
   endgenerate

   always_comb begin
      nxt = q_r;
      if (en_lo)
         nxt[BYTE_W-1:0] = acc_in;
      else if (en_hi)
         nxt[REG_W-1:BYTE_W] = acc_in;
      else if (en_inc || en_dec || en_adv)
         nxt = step_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= nxt;
   end

   assign q = q_r;

endmodule

// File: rtl/desig_regfile.sv
module desig_regfile
   import drf_pkg::*;
#(
   parameter int NUM_REGS     = 16,
   parameter int REG_W        = 16,
   parameter int BYTE_W       = 8,
   parameter bit SHARED_ADDER = 1'b1,
   localparam int SEL_W       = $clog2(NUM_REGS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [OPC_W-1:0]   op_code,
   input  logic [BYTE_W-1:0]  acc_in,
   input  logic               fetch_adv,
   output logic [REG_W-1:0]   pc_out,
   output logic [REG_W-1:0]   dp_out,
   output logic               acc_load,
   output logic [BYTE_W-1:0]  acc_data,
   output logic [2*SEL_W-1:0] t_out,
   output logic [SEL_W-1:0]   p_out,
   output logic [SEL_W-1:0]   x_out
);

   if (REG_W != 2 * BYTE_W) begin : g_chk_width
      $error("desig_regfile: REG_W must be twice BYTE_W");
   end
   if (SEL_W != NIB_W || NUM_REGS != (1 << NIB_W)) begin : g_chk_depth
      $error("desig_regfile: NUM_REGS must match the opcode register field");
   end
   if (BYTE_W != OPC_W) begin : g_chk_byte
      $error("desig_regfile: BYTE_W must equal the opcode width");
   end

   dec_op_t          dec;
   logic [SEL_W-1:0] p_q;
   logic [SEL_W-1:0] x_q;
   logic [SEL_W-1:0] op_sel;
   logic             is_write;
   logic [REG_W-1:0] rf_q [NUM_REGS];
   logic [REG_W-1:0] rd_word;

   drf_decode u_decode (
      .op_valid (op_valid),
      .op_code  (op_code),
      .dec      (dec)
   );

   drf_desig #(.SEL_W(SEL_W)) u_desig (
      .clk   (clk),
      .rst_n (rst_n),
      .dec   (dec),
      .p_q   (p_q),
      .x_q   (x_q),
      .t_q   (t_out)
   );

   assign op_sel   = SEL_W'(dec.sel);
   assign is_write = (dec.kind == K_INC) || (dec.kind == K_DEC) ||
                     (dec.kind == K_PLO) || (dec.kind == K_PHI);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic hit;
      logic adv_here;
      assign hit      = (op_sel == SEL_W'(i));
      assign adv_here = fetch_adv && (p_q == SEL_W'(i)) && !(is_write && hit);

      drf_cell #(
         .REG_W        (REG_W),
         .BYTE_W       (BYTE_W),
         .SHARED_ADDER (SHARED_ADDER)
      ) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .en_inc (hit && (dec.kind == K_INC)),
         .en_dec (hit && (dec.kind == K_DEC)),
         .en_lo  (hit && (dec.kind == K_PLO)),
         .en_hi  (hit && (dec.kind == K_PHI)),
         .en_adv (adv_here),
         .acc_in (acc_in),
         .q      (rf_q[i])
      );
   end

   assign rd_word  = rf_q[op_sel];
   assign pc_out   = rf_q[p_q];
   assign dp_out   = rf_q[x_q];
   assign acc_load = (dec.kind == K_GLO) || (dec.kind == K_GHI);
   assign acc_data = (dec.kind == K_GHI) ? rd_word[REG_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
   assign p_out    = p_q;
   assign x_out    = x_q;

endmodule

// File: rtl/desig_regfile_chk.sv
module desig_regfile_chk #(
   parameter int REG_W  = 16,
   parameter int BYTE_W = 8,
   parameter int SEL_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               op_valid,
   input logic [7:0]         op_code,
   input logic [BYTE_W-1:0]  acc_in,
   input logic               fetch_adv,
   input logic [REG_W-1:0]   pc_out,
   input logic [REG_W-1:0]   dp_out,
   input logic               acc_load,
   input logic [BYTE_W-1:0]  acc_data,
   input logic [2*SEL_W-1:0] t_out,
   input logic [SEL_W-1:0]   p_out,
   input logic [SEL_W-1:0]   x_out
);

   p_sep_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_code[7:4] == 4'hD |=> p_out == $past(op_code[3:0]));

   p_sex_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_code[7:4] == 4'hE |=> x_out == $past(op_code[3:0]));

   p_mark_save_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_code == 8'h79 |=> t_out == {$past(x_out), $past(p_out)});

   p_adv_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_adv && !op_valid |=> pc_out == $past(pc_out) + REG_W'(1));

   p_inc_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_adv && op_valid && op_code[7:4] == 4'h1 && op_code[3:0] == p_out
      |=> pc_out == $past(pc_out) + REG_W'(1));

   p_plo_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_adv && op_valid && op_code[7:4] == 4'hA && op_code[3:0] == p_out
      |=> pc_out[BYTE_W-1:0] == $past(acc_in) &&
          pc_out[REG_W-1:BYTE_W] == $past(pc_out[REG_W-1:BYTE_W]));

   p_glo_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_code[7:4] == 4'h8 && op_code[3:0] == p_out
      |-> acc_load && acc_data == pc_out[BYTE_W-1:0]);

   p_same_desig_r2: assert property (@(posedge clk) disable iff (!rst_n)
      p_out == x_out |-> pc_out == dp_out);

   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid && !fetch_adv |=> $stable(pc_out) && $stable(dp_out) &&
      $stable(t_out) && $stable(p_out) && $stable(x_out));

   p_no_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> !acc_load);

endmodule

bind desig_regfile desig_regfile_chk #(
   .REG_W  (REG_W),
   .BYTE_W (BYTE_W),
   .SEL_W  (SEL_W)
) u_chk (.*);

// File: tb/desig_regfile_tb.sv
`timescale 1ns/1ps
module desig_regfile_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [7:0]  op_code = 8'h00;
   logic [7:0]  acc_in = 8'h00;
   logic        fetch_adv = 1'b0;
   logic [15:0] pc_out, dp_out;
   logic        acc_load;
   logic [7:0]  acc_data, t_out;
   logic [3:0]  p_out, x_out;

   always #2 clk = ~clk;

   desig_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .acc_in(acc_in), .fetch_adv(fetch_adv), .pc_out(pc_out), .dp_out(dp_out),
      .acc_load(acc_load), .acc_data(acc_data), .t_out(t_out),
      .p_out(p_out), .x_out(x_out)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [15:0] m_reg [16];
   int m_p, m_x;
   logic [7:0] m_t;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 16; i++) m_reg[i] = 16'h0000;
      m_p = 0; m_x = 0; m_t = 8'h00;
   endtask

   task automatic compare_outputs(input bit v, input logic [7:0] code, input string tag);
      int hi = code[7:4];
      int n  = code[3:0];
      bit exp_load = v && (hi == 8 || hi == 9);
      check(pc_out == m_reg[m_p], tag, "pc_out", pc_out, m_reg[m_p]);
      check(dp_out == m_reg[m_x], tag, "dp_out", dp_out, m_reg[m_x]);
      check(p_out == 4'(m_p), tag, "p_out", 16'(p_out), 16'(m_p));
      check(x_out == 4'(m_x), tag, "x_out", 16'(x_out), 16'(m_x));
      check(t_out == m_t, tag, "t_out", 16'(t_out), 16'(m_t));
      check(acc_load == exp_load, tag, "acc_load", 16'(acc_load), 16'(exp_load));
      if (exp_load) begin
         logic [7:0] eb = (hi == 8) ? m_reg[n][7:0] : m_reg[n][15:8];
         check(acc_data == eb, tag, "acc_data", 16'(acc_data), 16'(eb));
      end
   endtask

   task automatic step(input bit v, input logic [7:0] code, input logic [7:0] acc,
                       input bit adv, input string tag);
      int hi, n, wr;
      logic [15:0] old_p_val;
      @(negedge clk);
      op_valid = v; op_code = code; acc_in = acc; fetch_adv = adv;
      #1;
      compare_outputs(v, code, tag);
      hi = code[7:4]; n = code[3:0]; wr = -1;
      old_p_val = m_reg[m_p];
      if (adv) begin
         if (v && (hi == 1 || hi == 2 || hi == 10 || hi == 11) && n == m_p) ;
         else m_reg[m_p] = old_p_val + 16'd1;
      end
      if (v) begin
         case (hi)
            1:  m_reg[n] = m_reg[n] + 16'd1;
            2:  m_reg[n] = m_reg[n] - 16'd1;
            10: m_reg[n][7:0] = acc;
            11: m_reg[n][15:8] = acc;
            13: m_p = n;
            14: m_x = n;
            7:  if (n == 9) m_t = {4'(m_x), 4'(m_p)};
            default: ;
         endcase
      end
      if (v && hi == 13 && adv) wr = n;
   endtask

   initial begin
      int lfsr;
      model_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      compare_outputs(1'b0, 8'h00, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 8'h00, 8'h00, 0, "R1");

      // R9: advance on register 0
      step(0, 8'h00, 8'h00, 1, "R9");
      step(0, 8'h00, 8'h00, 1, "R9");
      step(0, 8'hD0, 8'h00, 0, "R9");

      // R5 / R7: byte writes into r3, X pointed at it
      step(1, 8'hA3, 8'h5C, 0, "R5");
      step(1, 8'hB3, 8'hE1, 0, "R5");
      step(1, 8'hE3, 8'h00, 0, "R7");
      step(0, 8'h00, 8'h00, 0, "R7");

      // R3: wrap on r5
      step(1, 8'hA5, 8'hFF, 0, "R3");
      step(1, 8'hB5, 8'hFF, 0, "R3");
      step(1, 8'hE5, 8'h00, 0, "R3");
      step(1, 8'h15, 8'h00, 0, "R3");
      step(1, 8'h25, 8'h00, 0, "R3");
      step(1, 8'h25, 8'h00, 0, "R3");
      step(0, 8'h00, 8'h00, 0, "R3");

      // R6 / R9: P moves to r5 (0xFFFE) and advance wraps; SEP with advance uses old P
      step(1, 8'hD5, 8'h00, 1, "R6");
      step(0, 8'h00, 8'h00, 1, "R9");
      step(0, 8'h00, 8'h00, 1, "R9");
      step(0, 8'h00, 8'h00, 0, "R9");

      // R8: save designators
      step(1, 8'h79, 8'h00, 0, "R8");
      step(1, 8'hEA, 8'h00, 0, "R8");
      step(1, 8'h79, 8'h00, 0, "R8");
      step(0, 8'h00, 8'h00, 0, "R8");

      // R10: writes to the P register win over the advance
      step(1, 8'h15, 8'h00, 1, "R10");
      step(1, 8'h25, 8'h00, 1, "R10");
      step(1, 8'hA5, 8'h3A, 1, "R10");
      step(1, 8'hB5, 8'hC4, 1, "R10");
      step(1, 8'h13, 8'h00, 1, "R10");
      step(0, 8'h00, 8'h00, 0, "R10");

      // R11: ignored opcodes and op_valid low
      begin
         logic [7:0] ign [12] = '{8'h00, 8'h03, 8'h0F, 8'h35, 8'h47, 8'h5A,
                                  8'h62, 8'h78, 8'h7B, 8'hC5, 8'hF3, 8'hFE};
         for (int k = 0; k < 12; k++) step(1, ign[k], 8'hAA, 0, "R11");
         for (int k = 0; k < 12; k++) step(0, 8'h15 + 8'(k), 8'h55, 0, "R11");
      end

      // R4: read back every byte
      for (int r = 0; r < 16; r++) begin
         step(1, 8'h80 | 8'(r), 8'h00, 0, "R4");
         step(1, 8'h90 | 8'(r), 8'h00, 0, "R4");
      end

      // R2: long mixed sequence
      lfsr = 32'h1ACE_B00C;
      for (int c = 0; c < 600; c++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step(lfsr[8] | lfsr[9], lfsr[7:0], lfsr[23:16], lfsr[10], "R2");
      end
      for (int r = 0; r < 16; r++) begin
         step(1, 8'h80 | 8'(r), 8'h00, 0, "R2");
         step(1, 8'h90 | 8'(r), 8'h00, 0, "R2");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule